// File: doc/BRIEF.md
# Prescaled Timer Counter Core

This block is the time base of a timer unit: a 16-bit counter that advances on a prescaled tick and wraps at a programmable modulo value. The tick comes from one of two sources. It can be the module clock itself, or a synchronous enable pulse from an external source. A divider then scales that source by a power of two. The counter either counts upward only, or runs up to the modulo value and back down to zero. In the second form each period is symmetric, which is what centre-aligned waveforms in the channel logic need.

Each period end sets a sticky overflow flag, which can raise an interrupt. Sixteen trigger lines come into the block and one of them is selected. The selected trigger can hold the counter until it first appears, or it can force the count back to zero. A further option freezes the counter after its first overflow. Software controls the block through three write strobes: one for the control word, one for the modulo value and one that clears the counter. The count, the direction and a one-cycle reload strobe go to the neighbouring channel logic. A single pause input freezes all counting.

Top module: `ptc_timer`

## Requirements
- R1: Control bits [1:0] pick the count source: 1 counts on every clock, 2 counts only in cycles where `ext_tick_i` is high, and 0 or 3 stop counting.
- R2: Control bits [4:2] hold P, and the counter advances once every 2^P source events. The divider clears while the source is off, so after re-enabling, the first step needs a full 2^P events.
- R3: With control bit 5 at 0 (up-only), the count goes 0,1,...,MOD. The step after MOD returns it to 0, and that step is the overflow.
- R4: With control bit 5 at 1 (up-down), the count goes 0 up to MOD and back down. `count_down_o` is high while it falls. The overflow is the step that brings it back to 0, so one period is 2*MOD steps.
- R5: `ovf_flag_o` sets on each overflow. A control write with bit 7 at 1 clears it, and a control write with bit 7 at 0 leaves it unchanged.
- R6: `ovf_irq_o` is high exactly when the flag is set and control bit 6 (interrupt enable) is 1.
- R7: Control bits [11:8] select which `trig_i` line is used. With control bit 12 set, a control write that newly sets bit 12 holds the counter at its value until the selected line is seen high. Other lines have no effect.
- R8: With control bit 13 set, the selected trigger forces the count to 0 and the direction to up on the next edge.
- R9: With control bit 14 set, the counter stops after the first overflow, which leaves it at 0. It restarts only after a counter write.
- R10: A pulse on `cnt_we` sets the count to 0 and the direction to up. This takes priority over every other update.
- R11: While `pause_i` is high, neither the count nor the divider state changes.
- R12: `reload_o` is high for one cycle, together with a count of 0, after each overflow and after each trigger reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 15 | Control word value |
| mod_we | input | 1 | Modulo write strobe |
| mod_wdata | input | 16 | Modulo value |
| cnt_we | input | 1 | Counter clear strobe |
| ext_tick_i | input | 1 | External count enable |
| trig_i | input | 16 | Trigger lines |
| pause_i | input | 1 | Freeze counting |
| count_o | output | 16 | Current count |
| count_down_o | output | 1 | High while counting down |
| reload_o | output | 1 | One-cycle period-end / reload strobe |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_irq_o | output | 1 | Overflow interrupt |

## Verification
The main counting path is checked every cycle over a sweep. The sweep covers four prescale settings, two modulo values and both counting modes. The expected count, direction and flag come from the elapsed tick count using modulo arithmetic. This separates an off-by-one in the divider, in the wrap point and in the turn-around point of up-down mode. Directed patterns cover the remaining behaviour: an irregular external enable stream, the reserved source code, a pause inside a prescaled period, and re-enabling after a partial period. Trigger tests pulse both an unselected line and the selected line, which shows both the selection and the start and reload actions. Stop-on-overflow, the flag clear with bit 7 at 0 and at 1, and a counter clear during down-counting complete the set.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int PTC_PS_W   = 3;
    localparam int PTC_TSEL_W = 4;
    localparam int PTC_CTRL_W = 15;

    // Layout of a control word as written
    typedef struct packed {
        logic                  stop_ovf;
        logic                  reload_trg;
        logic                  start_trg;
        logic [PTC_TSEL_W-1:0] tsel;
        logic                  flag_clr;
        logic                  irq_en;
        logic                  updown;
        logic [PTC_PS_W-1:0]   ps;
        logic [1:0]            src;
    } ptc_wr_t;

    // Stored configuration (the clear bit is a strobe, not kept)
    typedef struct packed {
        logic                  stop_ovf;
        logic                  reload_trg;
        logic                  start_trg;
        logic [PTC_TSEL_W-1:0] tsel;
        logic                  irq_en;
        logic                  updown;
        logic [PTC_PS_W-1:0]   ps;
        logic [1:0]            src;
    } ptc_cfg_t;

endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      src_i,
    input  logic [PS_W-1:0] ps_i,
    input  logic            ext_tick_i,
    input  logic            pause_i,
    output logic            tick_o
);
    localparam int DIV_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_state_t;

    div_state_t s_q, s_d;
    logic [DIV_W-1:0] lim;
    logic             src_on, src_evt;

    always_comb begin
        s_d     = s_q;
        lim     = DIV_W'((32'd1 << ps_i) - 32'd1);
        src_on  = (src_i == 2'd1) || (src_i == 2'd2);
        src_evt = (src_i == 2'd1) || ((src_i == 2'd2) && ext_tick_i);
        tick_o  = src_evt && !pause_i && (s_q.div >= lim);
        if (!src_on) begin
            s_d.div = '0;
        end else if (src_evt && !pause_i) begin
            s_d.div = (s_q.div >= lim) ? '0 : s_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    div_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == 2'd0 || src_i == 2'd3) |=> (s_q.div == '0));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && ps_i != '0) |=> (!tick_o || ps_i == '0));

endmodule

// File: rtl/ptc_trig_sel.sv
module ptc_trig_sel #(
    parameter int SEL_W = 4
) (
    input  logic [(1<<SEL_W)-1:0] trig_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic                  hit_o
);
    localparam int N = 1 << SEL_W;

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_line
        assign match[g] = trig_i[g] && (sel_i == SEL_W'(g));
    end

    assign hit_o = |match;

endmodule

// File: rtl/ptc_count_core.sv
module ptc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             trig_hit_i,
    input  logic             updown_i,
    input  logic             sot_i,
    input  logic             sot_arm_i,
    input  logic             rot_i,
    input  logic             soo_i,
    input  logic [CNT_W-1:0] mod_i,
    input  logic             cnt_clr_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             flag_o,
    output logic             reload_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             flag;
        logic             started;
        logic             stopped;
        logic             reload;
    } core_state_t;

    core_state_t s_q, s_d;
    logic        run, ovf;

    always_comb begin
        s_d        = s_q;
        s_d.reload = 1'b0;
        ovf        = 1'b0;
        run        = tick_i && (!sot_i || s_q.started) && !(soo_i && s_q.stopped);

        if (sot_arm_i)          s_d.started = 1'b0;
        if (trig_hit_i && sot_i) s_d.started = 1'b1;

        if (cnt_clr_i) begin
            s_d.cnt     = '0;
            s_d.down    = 1'b0;
            s_d.stopped = 1'b0;
        end else if (trig_hit_i && rot_i) begin
            s_d.cnt    = '0;
            s_d.down   = 1'b0;
            s_d.reload = 1'b1;
        end else if (run) begin
            if (!updown_i) begin
                s_d.down = 1'b0;
                if (s_q.cnt >= mod_i) begin
                    s_d.cnt = '0;
                    ovf     = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end else if (!s_q.down) begin
                if (s_q.cnt >= mod_i) begin
                    if (s_q.cnt <= CNT_W'(1)) begin
                        s_d.cnt = '0;
                        ovf     = 1'b1;
                    end else begin
                        s_d.cnt  = s_q.cnt - CNT_W'(1);
                        s_d.down = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end else begin
                if (s_q.cnt <= CNT_W'(1)) begin
                    s_d.cnt  = '0;
                    s_d.down = 1'b0;
                    ovf      = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
        end

        if (ovf) begin
            s_d.reload = 1'b1;
            if (soo_i) s_d.stopped = 1'b1;
        end

        if (ovf)            s_d.flag = 1'b1;
        else if (ovf_clr_i) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o    = s_q.cnt;
    assign down_o   = s_q.down;
    assign flag_o   = s_q.flag;
    assign reload_o = s_q.reload;

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_i |=> (cnt_o == '0 && !down_o));

    // R5
    flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr_i && !tick_i) |=> !flag_o);

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soo_i && s_q.stopped && !cnt_clr_i && !(trig_hit_i && rot_i)) |=> $stable(cnt_o));

    // R12
    reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |-> (cnt_o == '0));

endmodule

// File: rtl/ptc_timer.sv
module ptc_timer
    import ptc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic [PTC_CTRL_W-1:0] ctrl_wdata,
    input  logic                  mod_we,
    input  logic [CNT_W-1:0]      mod_wdata,
    input  logic                  cnt_we,
    input  logic                  ext_tick_i,
    input  logic [(1<<PTC_TSEL_W)-1:0] trig_i,
    input  logic                  pause_i,
    output logic [CNT_W-1:0]      count_o,
    output logic                  count_down_o,
    output logic                  reload_o,
    output logic                  ovf_flag_o,
    output logic                  ovf_irq_o
);
    typedef struct packed {
        ptc_cfg_t         cfg;
        logic [CNT_W-1:0] modv;
    } top_state_t;

    top_state_t s_q, s_d;
    ptc_wr_t    wr;
    logic       sot_arm, flag_clr, tick, trig_hit;

    always_comb begin
        wr       = ptc_wr_t'(ctrl_wdata);
        s_d      = s_q;
        sot_arm  = ctrl_we && wr.start_trg && !s_q.cfg.start_trg;
        flag_clr = ctrl_we && wr.flag_clr;
        if (ctrl_we) begin
            s_d.cfg.stop_ovf   = wr.stop_ovf;
            s_d.cfg.reload_trg = wr.reload_trg;
            s_d.cfg.start_trg  = wr.start_trg;
            s_d.cfg.tsel       = wr.tsel;
            s_d.cfg.irq_en     = wr.irq_en;
            s_d.cfg.updown     = wr.updown;
            s_d.cfg.ps         = wr.ps;
            s_d.cfg.src        = wr.src;
        end
        if (mod_we) s_d.modv = mod_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    ptc_prescaler #(.PS_W(PTC_PS_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (s_q.cfg.src),
        .ps_i       (s_q.cfg.ps),
        .ext_tick_i (ext_tick_i),
        .pause_i    (pause_i),
        .tick_o     (tick)
    );

    ptc_trig_sel #(.SEL_W(PTC_TSEL_W)) u_tsel (
        .trig_i (trig_i),
        .sel_i  (s_q.cfg.tsel),
        .hit_o  (trig_hit)
    );

    ptc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .trig_hit_i (trig_hit),
        .updown_i   (s_q.cfg.updown),
        .sot_i      (s_q.cfg.start_trg),
        .sot_arm_i  (sot_arm),
        .rot_i      (s_q.cfg.reload_trg),
        .soo_i      (s_q.cfg.stop_ovf),
        .mod_i      (s_q.modv),
        .cnt_clr_i  (cnt_we),
        .ovf_clr_i  (flag_clr),
        .cnt_o      (count_o),
        .down_o     (count_down_o),
        .flag_o     (ovf_flag_o),
        .reload_o   (reload_o)
    );

    assign ovf_irq_o = ovf_flag_o && s_q.cfg.irq_en;

endmodule

// File: tb/ptc_timer_tb.sv
`timescale 1ns/1ps
module ptc_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [14:0] ctrl_wdata = '0;
    logic        mod_we = 1'b0;
    logic [15:0] mod_wdata = '0;
    logic        cnt_we = 1'b0;
    logic        ext_tick_i = 1'b0;
    logic [15:0] trig_i = '0;
    logic        pause_i = 1'b0;
    logic [15:0] count_o;
    logic        count_down_o, reload_o, ovf_flag_o, ovf_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ptc_timer dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .mod_we(mod_we), .mod_wdata(mod_wdata), .cnt_we(cnt_we),
        .ext_tick_i(ext_tick_i), .trig_i(trig_i), .pause_i(pause_i),
        .count_o(count_o), .count_down_o(count_down_o), .reload_o(reload_o),
        .ovf_flag_o(ovf_flag_o), .ovf_irq_o(ovf_irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // bits: [14] stop, [13] reload-trig, [12] start-trig, [11:8] sel,
    // [7] flag clear, [6] irq en, [5] up-down, [4:2] ps, [1:0] source
    function automatic logic [14:0] mk(int src, int ps, int ud, int ie, int clr,
                                       int ts, int sot, int rot, int soo);
        return {1'(soo), 1'(rot), 1'(sot), 4'(ts), 1'(clr), 1'(ie), 1'(ud), 3'(ps), 2'(src)};
    endfunction

    task automatic wr_ctrl(input logic [14:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_mod(input int v);
        @(negedge clk); mod_we = 1'b1; mod_wdata = 16'(v);
        @(negedge clk); mod_we = 1'b0;
    endtask

    task automatic wr_cnt();
        @(negedge clk); cnt_we = 1'b1;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic restart(input int m);
        wr_ctrl(mk(0, 0, 0, 0, 1, 0, 0, 0, 0));
        wr_mod(m);
        wr_cnt();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int expc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R10 reset count", int'(count_o), 0);
        check("R5 reset flag", int'(ovf_flag_o), 0);
        check("R12 reset reload", int'(reload_o), 0);
        check("R6 reset irq", int'(ovf_irq_o), 0);

        // Sweep: prescale x modulo x mode (R2, R3, R4, R5, R6)
        for (int ps = 0; ps < 4; ps++) begin
            for (int mi = 0; mi < 2; mi++) begin
                for (int ud = 0; ud < 2; ud++) begin
                    int m, d, per, n_max;
                    m = (mi != 0) ? 5 : 2;
                    d = 1 << ps;
                    per = (ud != 0) ? 2 * m : m + 1;
                    n_max = 2 * per * d + 2;
                    restart(m);
                    wr_ctrl(mk(1, ps, ud, ud, 1, 0, 0, 0, 0));
                    for (int n = 1; n <= n_max; n++) begin
                        int t, p, ec, ed, ef;
                        @(negedge clk);
                        t = n / d;
                        p = t % per;
                        if (ud != 0) begin
                            ec = (p <= m) ? p : 2 * m - p;
                            ed = (p > m) ? 1 : 0;
                        end else begin
                            ec = p;
                            ed = 0;
                        end
                        ef = (t >= per) ? 1 : 0;
                        if (ud != 0) begin
                            check("R4 R2 count", int'(count_o), ec);
                            check("R4 direction", int'(count_down_o), ed);
                        end else begin
                            check("R3 R2 count", int'(count_o), ec);
                        end
                        check("R5 flag", int'(ovf_flag_o), ef);
                        check("R6 irq", int'(ovf_irq_o), ef & ud);
                    end
                end
            end
        end

        // R1 external enable, irregular stream
        restart(1000);
        wr_ctrl(mk(2, 0, 0, 0, 1, 0, 0, 0, 0));
        expc = 0;
        for (int i = 0; i < 14; i++) begin
            ext_tick_i = ((i % 3) == 0) || (i == 7);
            @(negedge clk);
            if (ext_tick_i) expc++;
        end
        ext_tick_i = 1'b0;
        check("R1 external source count", int'(count_o), expc);

        // R1 reserved source code does not count
        restart(1000);
        wr_ctrl(mk(3, 0, 0, 0, 1, 0, 0, 0, 0));
        step(10);
        check("R1 reserved source", int'(count_o), 0);

        // R11 pause inside prescaled period
        restart(1000);
        wr_ctrl(mk(1, 1, 0, 0, 1, 0, 0, 0, 0));
        step(6);
        check("R11 before pause", int'(count_o), 3);
        pause_i = 1'b1;
        step(9);
        check("R11 during pause", int'(count_o), 3);
        pause_i = 1'b0;
        step(3);
        check("R11 after pause", int'(count_o), 4);

        // R2 divider cleared while disabled
        restart(1000);
        wr_ctrl(mk(1, 2, 0, 0, 1, 0, 0, 0, 0));
        step(5);
        check("R2 partial period", int'(count_o), 1);
        wr_ctrl(mk(0, 2, 0, 0, 0, 0, 0, 0, 0));
        step(3);
        wr_ctrl(mk(1, 2, 0, 0, 0, 0, 0, 0, 0));
        step(3);
        check("R2 full period not yet", int'(count_o), 1);
        step(1);
        check("R2 full period reached", int'(count_o), 2);

        // R7 start on selected trigger
        restart(1000);
        wr_ctrl(mk(1, 0, 0, 0, 1, 5, 1, 0, 0));
        step(5);
        check("R7 held before trigger", int'(count_o), 0);
        trig_i[4] = 1'b1; @(negedge clk); trig_i[4] = 1'b0;
        step(3);
        check("R7 unselected trigger ignored", int'(count_o), 0);
        trig_i[5] = 1'b1; @(negedge clk); trig_i[5] = 1'b0;
        check("R7 start edge", int'(count_o), 0);
        step(4);
        check("R7 running after trigger", int'(count_o), 4);

        // R8 / R12 reload on selected trigger
        restart(1000);
        wr_ctrl(mk(1, 0, 0, 0, 1, 2, 0, 1, 0));
        step(7);
        check("R8 before trigger", int'(count_o), 7);
        trig_i[3] = 1'b1; @(negedge clk); trig_i[3] = 1'b0;
        check("R8 unselected line", int'(count_o), 8);
        trig_i[2] = 1'b1; @(negedge clk); trig_i[2] = 1'b0;
        check("R8 reloaded", int'(count_o), 0);
        check("R12 strobe on trigger reload", int'(reload_o), 1);
        @(negedge clk);
        check("R8 counting again", int'(count_o), 1);
        check("R12 strobe one cycle", int'(reload_o), 0);

        // R9 / R12 stop on overflow
        restart(3);
        wr_ctrl(mk(1, 0, 0, 0, 1, 0, 0, 0, 1));
        step(3);
        check("R9 at top", int'(count_o), 3);
        step(1);
        check("R9 wrapped", int'(count_o), 0);
        check("R12 strobe on wrap", int'(reload_o), 1);
        step(6);
        check("R9 stopped", int'(count_o), 0);
        wr_cnt();
        step(2);
        check("R9 restarted by counter write", int'(count_o), 2);

        // R5 / R6 flag clear semantics (flag set from previous test)
        wr_ctrl(mk(0, 0, 0, 1, 0, 0, 0, 0, 0));
        check("R5 write 0 keeps flag", int'(ovf_flag_o), 1);
        check("R6 irq enabled", int'(ovf_irq_o), 1);
        wr_ctrl(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
        check("R6 irq masked", int'(ovf_irq_o), 0);
        check("R5 flag still set", int'(ovf_flag_o), 1);
        wr_ctrl(mk(0, 0, 0, 1, 1, 0, 0, 0, 0));
        check("R5 write 1 clears", int'(ovf_flag_o), 0);
        check("R6 irq after clear", int'(ovf_irq_o), 0);

        // R10 counter write while counting down
        restart(3);
        wr_ctrl(mk(1, 0, 1, 0, 1, 0, 0, 0, 0));
        step(5);
        check("R10 precondition count", int'(count_o), 1);
        check("R10 precondition down", int'(count_down_o), 1);
        wr_cnt();
        check("R10 cleared count", int'(count_o), 0);
        check("R10 direction up", int'(count_down_o), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule